// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the serial test port of a processor. It runs the sixteen-state test state machine on the test clock and mode inputs. It also holds a four-bit instruction register and its decoder, and it steers one of four data paths between the serial input and the serial output. The four paths are a one-bit bypass stage, a 32-bit identification word, a one-bit self-test result and a 192-cell boundary chain. The boundary cells themselves are not part of the block. The block gives them the captured-pin input and a latched update vector, together with global drive, clamp and float controls.

A self-test engine outside the block receives a start pulse from it and returns a pass flag. Serial output changes on the falling test-clock edge and comes with an enable that is high only while a register is being shifted. The active-low test reset acts at once, and its release is synchronised to the test clock.

Top module: `tap_port`

## Requirements
- R1: The controller follows the standard sixteen-state graph on each rising tck edge. The pause and exit states let a data shift be suspended and resumed without loss. Five consecutive rising edges with tms high bring it to Test-Logic-Reset from any state.
- R2: trst_n low immediately forces Test-Logic-Reset, sets the current instruction to the ID code 0010, clears tdo_oe, clamp_mode, highz_mode and bsr_drive, and zeroes bsr_update. The ID path is then the default data path.
- R3: In Capture-IR the instruction shift stage loads 0001. Shift-IR moves it towards tdo least significant bit first, with tdi entering bit 3.
- R4: The current instruction is taken from the shift stage on the falling tck edge in Update-IR. The decode is: 0000 boundary drive, 0001 boundary sample, 0010 ID, 0111 self-test, 0100 clamp, 1000 float, 1111 bypass. Every other code, including the reserved codes 1011, 1100, 0101 and 0110, acts as bypass.
- R5: With the ID path selected, Capture-DR loads 0x08864013, which is shifted out least significant bit first.
- R6: Bypass, clamp, float and all undefined codes route a one-bit stage that captures 0 in Capture-DR.
- R7: The self-test code routes a one-bit stage that captures bist_pass in Capture-DR. While that code is current, bist_start is high for exactly one tck cycle on each entry into Run-Test/Idle.
- R8: Both boundary codes (0000, 0001) route the 192-cell chain. Capture-DR loads bsr_capture, cell 0 is the first bit out on tdo, and tdi enters cell 191. bsr_update takes the chain contents on the falling edge in Update-DR. For every other instruction bsr_update holds its value.
- R9: bsr_drive is high for codes 0000 and 0100, clamp_mode for 0100 only, and highz_mode for 1000 only. highz_mode disables all pin drivers, so it is never high together with bsr_drive.
- R10: tdo and tdo_oe change only on the falling tck edge. tdo_oe is high exactly during Shift-IR and Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Test mode select, sampled on rising tck |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, falling-edge timed |
| tdo_oe | output | 1 | Output enable for tdo |
| bsr_capture | input | 192 | Pin values loaded into the boundary chain in Capture-DR |
| bsr_update | output | 192 | Latched boundary chain contents towards the cells |
| bsr_drive | output | 1 | Boundary cells drive pins from bsr_update |
| clamp_mode | output | 1 | Clamp instruction active |
| highz_mode | output | 1 | All pin drivers disabled |
| bist_start | output | 1 | One-cycle self-test start pulse |
| bist_pass | input | 1 | Self-test pass flag from the engine |

## Verification
The assertions check on every cycle that five high tms samples always reach reset and that the reset state always holds the ID code. They also check the capture values of the IR and of the bypass and ID paths, as seen in the first tdo bit after capture, as well as the timing of tdo_oe, the single-cycle start pulse and the exclusion between float and drive. The bench sweeps all sixteen opcodes with both self-test results. For each opcode it measures the path length and the captured contents through a 200-bit scan, and it tracks the boundary update latch against a model. Only these scenarios can show the full decode table, the 192-cell ordering, a shift suspended in Pause-DR and the immediate action of trst_n in the middle of a cycle.

// File: rtl/tap_pkg.sv
`timescale 1ns/1ps
package tap_pkg;
  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_DR_SEL, ST_DR_CAP, ST_DR_SHIFT, ST_DR_EX1, ST_DR_PAUSE, ST_DR_EX2, ST_DR_UPD,
    ST_IR_SEL, ST_IR_CAP, ST_IR_SHIFT, ST_IR_EX1, ST_IR_PAUSE, ST_IR_EX2, ST_IR_UPD
  } tap_state_e;

  typedef enum logic [1:0] {PATH_BYPASS, PATH_ID, PATH_BIST, PATH_BOUND} dr_path_e;

  localparam int OPC_W = 4;
  localparam logic [OPC_W-1:0] OPC_EXTEST  = 4'b0000;
  localparam logic [OPC_W-1:0] OPC_SAMPLE  = 4'b0001;
  localparam logic [OPC_W-1:0] OPC_IDCODE  = 4'b0010;
  localparam logic [OPC_W-1:0] OPC_CLAMP   = 4'b0100;
  localparam logic [OPC_W-1:0] OPC_RUNBIST = 4'b0111;
  localparam logic [OPC_W-1:0] OPC_HIGHZ   = 4'b1000;
  localparam logic [OPC_W-1:0] OPC_BYPASS  = 4'b1111;
  localparam logic [OPC_W-1:0] IR_CAP_PAT  = 4'b0001;
endpackage

// File: rtl/tap_fsm.sv
`timescale 1ns/1ps
module tap_fsm
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e state
);
  tap_state_e state_d;

  always_comb begin
    state_d = state;
    unique case (state)
      ST_RESET:    state_d = tms ? ST_RESET    : ST_IDLE;
      ST_IDLE:     state_d = tms ? ST_DR_SEL   : ST_IDLE;
      ST_DR_SEL:   state_d = tms ? ST_IR_SEL   : ST_DR_CAP;
      ST_DR_CAP:   state_d = tms ? ST_DR_EX1   : ST_DR_SHIFT;
      ST_DR_SHIFT: state_d = tms ? ST_DR_EX1   : ST_DR_SHIFT;
      ST_DR_EX1:   state_d = tms ? ST_DR_UPD   : ST_DR_PAUSE;
      ST_DR_PAUSE: state_d = tms ? ST_DR_EX2   : ST_DR_PAUSE;
      ST_DR_EX2:   state_d = tms ? ST_DR_UPD   : ST_DR_SHIFT;
      ST_DR_UPD:   state_d = tms ? ST_DR_SEL   : ST_IDLE;
      ST_IR_SEL:   state_d = tms ? ST_RESET    : ST_IR_CAP;
      ST_IR_CAP:   state_d = tms ? ST_IR_EX1   : ST_IR_SHIFT;
      ST_IR_SHIFT: state_d = tms ? ST_IR_EX1   : ST_IR_SHIFT;
      ST_IR_EX1:   state_d = tms ? ST_IR_UPD   : ST_IR_PAUSE;
      ST_IR_PAUSE: state_d = tms ? ST_IR_EX2   : ST_IR_PAUSE;
      ST_IR_EX2:   state_d = tms ? ST_IR_UPD   : ST_IR_SHIFT;
      ST_IR_UPD:   state_d = tms ? ST_DR_SEL   : ST_IDLE;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state <= ST_RESET;
    else        state <= state_d;
  end
endmodule

// File: rtl/tap_ir.sv
`timescale 1ns/1ps
module tap_ir
  import tap_pkg::*;
(
  input  logic             tck,
  input  logic             rst_n,
  input  tap_state_e       state,
  input  logic             tdi,
  output logic             ir_lsb,
  output logic [OPC_W-1:0] ir_cur,
  output dr_path_e         dr_path,
  output logic             clamp_o,
  output logic             highz_o,
  output logic             drive_o
);
  logic [OPC_W-1:0] ir_sh;
  logic             sh_cap, sh_en, upd_en, rst_ld;

  assign sh_cap = (state == ST_IR_CAP);
  assign sh_en  = (state == ST_IR_SHIFT);
  assign upd_en = (state == ST_IR_UPD);
  assign rst_ld = (state == ST_RESET);

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)      ir_sh <= IR_CAP_PAT;
    else if (sh_cap) ir_sh <= IR_CAP_PAT;
    else if (sh_en)  ir_sh <= {tdi, ir_sh[OPC_W-1:1]};
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n)      ir_cur <= OPC_IDCODE;
    else if (rst_ld) ir_cur <= OPC_IDCODE;
    else if (upd_en) ir_cur <= ir_sh;
  end

  assign ir_lsb = ir_sh[0];

  always_comb begin
    dr_path = PATH_BYPASS;
    clamp_o = 1'b0;
    highz_o = 1'b0;
    drive_o = 1'b0;
    case (ir_cur)
      OPC_EXTEST:  begin dr_path = PATH_BOUND; drive_o = 1'b1; end
      OPC_SAMPLE:  dr_path = PATH_BOUND;
      OPC_IDCODE:  dr_path = PATH_ID;
      OPC_RUNBIST: dr_path = PATH_BIST;
      OPC_CLAMP:   begin clamp_o = 1'b1; drive_o = 1'b1; end
      OPC_HIGHZ:   highz_o = 1'b1;
      default:     dr_path = PATH_BYPASS;
    endcase
  end
endmodule

// File: rtl/tap_dr.sv
`timescale 1ns/1ps
module tap_dr
  import tap_pkg::*;
#(
  parameter int          BSR_LEN  = 192,
  parameter logic [31:0] ID_VALUE = 32'h0886_4013
) (
  input  logic               tck,
  input  logic               rst_n,
  input  tap_state_e         state,
  input  dr_path_e           dr_path,
  input  logic               tdi,
  input  logic               bist_pass,
  input  logic [BSR_LEN-1:0] bsr_capture,
  output logic               dr_lsb,
  output logic [BSR_LEN-1:0] bsr_update
);
  localparam int ID_W = 32;

  logic               cap, sh, upd;
  logic               byp_q, bist_q;
  logic [ID_W-1:0]    id_sh;
  logic [BSR_LEN-1:0] bsr_sh;

  assign cap = (state == ST_DR_CAP);
  assign sh  = (state == ST_DR_SHIFT);
  assign upd = (state == ST_DR_UPD) && (dr_path == PATH_BOUND);

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)                                byp_q <= 1'b0;
    else if (cap && dr_path == PATH_BYPASS)    byp_q <= 1'b0;
    else if (sh && dr_path == PATH_BYPASS)     byp_q <= tdi;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)                                bist_q <= 1'b0;
    else if (cap && dr_path == PATH_BIST)      bist_q <= bist_pass;
    else if (sh && dr_path == PATH_BIST)       bist_q <= tdi;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)                                id_sh <= '0;
    else if (cap && dr_path == PATH_ID)        id_sh <= ID_VALUE;
    else if (sh && dr_path == PATH_ID)         id_sh <= {tdi, id_sh[ID_W-1:1]};
  end

  generate
    if (BSR_LEN > 1) begin : g_chain
      always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n)                            bsr_sh <= '0;
        else if (cap && dr_path == PATH_BOUND) bsr_sh <= bsr_capture;
        else if (sh && dr_path == PATH_BOUND)  bsr_sh <= {tdi, bsr_sh[BSR_LEN-1:1]};
      end
    end else begin : g_single
      always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n)                            bsr_sh <= '0;
        else if (cap && dr_path == PATH_BOUND) bsr_sh <= bsr_capture;
        else if (sh && dr_path == PATH_BOUND)  bsr_sh <= tdi;
      end
    end
  endgenerate

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n)   bsr_update <= '0;
    else if (upd) bsr_update <= bsr_sh;
  end

  always_comb begin
    unique case (dr_path)
      PATH_BYPASS: dr_lsb = byp_q;
      PATH_ID:     dr_lsb = id_sh[0];
      PATH_BIST:   dr_lsb = bist_q;
      PATH_BOUND:  dr_lsb = bsr_sh[0];
    endcase
  end
endmodule

// File: rtl/tap_port.sv
`timescale 1ns/1ps
module tap_port
  import tap_pkg::*;
#(
  parameter int          BSR_LEN  = 192,
  parameter logic [31:0] ID_VALUE = 32'h0886_4013
) (
  input  logic               tck,
  input  logic               trst_n,
  input  logic               tms,
  input  logic               tdi,
  output logic               tdo,
  output logic               tdo_oe,
  input  logic [BSR_LEN-1:0] bsr_capture,
  output logic [BSR_LEN-1:0] bsr_update,
  output logic               bsr_drive,
  output logic               clamp_mode,
  output logic               highz_mode,
  output logic               bist_start,
  input  logic               bist_pass
);
  logic [1:0]       rst_sync;
  logic             rst_n;
  tap_state_e       state;
  logic [OPC_W-1:0] ir_cur;
  dr_path_e         dr_path;
  logic             ir_lsb, dr_lsb;
  logic             in_sh_ir, in_sh_dr;
  logic             idle_prev;

  // assertion asynchronous, release aligned to tck
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) rst_sync <= 2'b00;
    else         rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n = rst_sync[1];

  tap_fsm u_fsm (
    .tck   (tck),
    .rst_n (rst_n),
    .tms   (tms),
    .state (state)
  );

  tap_ir u_ir (
    .tck     (tck),
    .rst_n   (rst_n),
    .state   (state),
    .tdi     (tdi),
    .ir_lsb  (ir_lsb),
    .ir_cur  (ir_cur),
    .dr_path (dr_path),
    .clamp_o (clamp_mode),
    .highz_o (highz_mode),
    .drive_o (bsr_drive)
  );

  tap_dr #(.BSR_LEN(BSR_LEN), .ID_VALUE(ID_VALUE)) u_dr (
    .tck         (tck),
    .rst_n       (rst_n),
    .state       (state),
    .dr_path     (dr_path),
    .tdi         (tdi),
    .bist_pass   (bist_pass),
    .bsr_capture (bsr_capture),
    .dr_lsb      (dr_lsb),
    .bsr_update  (bsr_update)
  );

  assign in_sh_ir = (state == ST_IR_SHIFT);
  assign in_sh_dr = (state == ST_DR_SHIFT);

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= in_sh_ir || in_sh_dr;
      if (in_sh_ir)      tdo <= ir_lsb;
      else if (in_sh_dr) tdo <= dr_lsb;
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) idle_prev <= 1'b0;
    else        idle_prev <= (state == ST_IDLE);
  end

  assign bist_start = (state == ST_IDLE) && !idle_prev && (dr_path == PATH_BIST);
endmodule

// File: rtl/tap_port_chk.sv
`timescale 1ns/1ps
module tap_port_chk
  import tap_pkg::*;
(
  input logic             tck,
  input logic             rst_n,
  input logic             tms,
  input tap_state_e       state,
  input logic [OPC_W-1:0] ir_cur,
  input dr_path_e         dr_path,
  input logic             tdo,
  input logic             tdo_oe,
  input logic             bist_start,
  input logic             clamp_mode,
  input logic             highz_mode,
  input logic             bsr_drive
);
  logic [2:0] ones;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)            ones <= 3'd0;
    else if (!tms)         ones <= 3'd0;
    else if (ones != 3'd5) ones <= ones + 3'd1;
  end

  assert_five_ones_reset_R1: assert property (@(posedge tck) disable iff (!rst_n)
    (ones == 3'd5) |-> (state == ST_RESET));

  assert_reset_holds_id_R2: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_RESET) |-> (ir_cur == OPC_IDCODE));

  assert_ir_capture_first_bit_R3: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_IR_CAP) ##1 (state == ST_IR_SHIFT) |-> tdo);

  assert_id_first_bit_R5: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_DR_CAP && dr_path == PATH_ID) ##1 (state == ST_DR_SHIFT) |-> tdo);

  assert_bypass_first_bit_R6: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_DR_CAP && dr_path == PATH_BYPASS) ##1 (state == ST_DR_SHIFT) |-> !tdo);

  assert_bist_single_pulse_R7: assert property (@(posedge tck) disable iff (!rst_n)
    bist_start |=> !bist_start);

  assert_float_excludes_drive_R9: assert property (@(posedge tck) disable iff (!rst_n)
    !(highz_mode && (bsr_drive || clamp_mode)));

  assert_oe_in_shift_R10: assert property (@(posedge tck) disable iff (!rst_n)
    tdo_oe == (state == ST_IR_SHIFT || state == ST_DR_SHIFT));
endmodule

bind tap_port tap_port_chk u_chk (
  .tck        (tck),
  .rst_n      (rst_n),
  .tms        (tms),
  .state      (state),
  .ir_cur     (ir_cur),
  .dr_path    (dr_path),
  .tdo        (tdo),
  .tdo_oe     (tdo_oe),
  .bist_start (bist_start),
  .clamp_mode (clamp_mode),
  .highz_mode (highz_mode),
  .bsr_drive  (bsr_drive)
);

// File: tb/tap_port_tb.sv
`timescale 1ns/1ps
module tap_port_tb;
  localparam int BL = 192;
  localparam logic [31:0] IDV = 32'h0886_4013;

  logic          tck = 1'b0;
  logic          trst_n = 1'b0;
  logic          tms = 1'b1;
  logic          tdi = 1'b0;
  logic          bist_pass = 1'b0;
  logic [BL-1:0] bsr_cap = '0;
  logic          tdo, tdo_oe, bsr_drive, clamp_mode, highz_mode, bist_start;
  logic [BL-1:0] bsr_update;

  int checks = 0;
  int failures = 0;
  int bist_cnt = 0;
  bit done = 0;

  always #2.5 tck = ~tck;

  tap_port u_dut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .bsr_capture(bsr_cap), .bsr_update(bsr_update), .bsr_drive(bsr_drive),
    .clamp_mode(clamp_mode), .highz_mode(highz_mode), .bist_start(bist_start),
    .bist_pass(bist_pass)
  );

  always @(negedge tck) if (bist_start === 1'b1) bist_cnt++;

  task automatic chk(input bit ok, input string req, input logic [255:0] got, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // sample tdo/oe set at this falling edge, then drive next tms/tdi
  task automatic step(input logic m, input logic d, output logic o, output logic oe);
    @(negedge tck); #1;
    o = tdo; oe = tdo_oe;
    tms = m; tdi = d;
    @(posedge tck);
  endtask

  task automatic step0(input logic m);
    logic o, oe;
    step(m, 1'b0, o, oe);
  endtask

  task automatic load_ir(input logic [3:0] op, output logic [3:0] cap, output bit oe_ok);
    logic o, oe;
    oe_ok = 1;
    step0(1); step0(1); step0(0);
    step(0, 0, o, oe); if (oe) oe_ok = 0;
    for (int i = 0; i < 4; i++) begin
      step(i == 3, op[i], o, oe);
      cap[i] = o;
      if (!oe) oe_ok = 0;
    end
    step0(1); step0(0);
  endtask

  task automatic scan_dr(input logic [255:0] din, input int n, output logic [255:0] dout, output bit oe_ok);
    logic o, oe;
    oe_ok = 1;
    dout = '0;
    step(1, 0, o, oe); if (oe) oe_ok = 0;
    step0(0); step0(0);
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i], o, oe);
      dout[i] = o;
      if (!oe) oe_ok = 0;
    end
    step(1, 0, o, oe); if (oe) oe_ok = 0;
    step0(0);
  endtask

  task automatic read_id(input string req);
    logic [255:0] d, q;
    bit oe_ok;
    d = '0;
    scan_dr(d, 32, q, oe_ok);
    chk(q[31:0] == IDV, req, {224'd0, q[31:0]}, {224'd0, IDV});
  endtask

  initial begin
    logic [3:0]    capo;
    logic [255:0]  din, dout, exp;
    logic [BL-1:0] upd_model;
    bit            oe_ok;
    int            plen;

    // reset state (R2)
    repeat (4) @(posedge tck);
    @(negedge tck); #1;
    chk(tdo_oe == 0 && clamp_mode == 0 && highz_mode == 0 && bsr_drive == 0, "R2 reset outputs",
        {252'd0, tdo_oe, clamp_mode, highz_mode, bsr_drive}, 256'd0);
    chk(bsr_update == '0, "R2 reset bsr_update", {64'd0, bsr_update}, 256'd0);
    trst_n = 1;
    repeat (4) step0(1);
    step0(0);
    read_id("R2 R5 default path is ID");
    upd_model = '0;

    // pause-DR suspend/resume of ID scan (R1)
    begin
      logic o, oe;
      logic [31:0] got;
      bit pause_oe_ok;
      pause_oe_ok = 1;
      step0(1); step0(0); step0(0);
      for (int i = 0; i < 16; i++) begin step(i == 15, 0, o, oe); got[i] = o; end
      step(0, 0, o, oe);
      step(0, 0, o, oe); if (oe) pause_oe_ok = 0;
      step(1, 0, o, oe); if (oe) pause_oe_ok = 0;
      step(0, 0, o, oe); if (oe) pause_oe_ok = 0;
      for (int i = 16; i < 32; i++) begin step(i == 31, 0, o, oe); got[i] = o; end
      step0(1); step0(0);
      chk(got == IDV, "R1 pause-DR resume keeps ID shift", {224'd0, got}, {224'd0, IDV});
      chk(pause_oe_ok, "R10 oe low during pause", {255'd0, pause_oe_ok}, 256'd1);
    end

    // opcode sweep with both self-test results (R3 R4 R5 R6 R7 R8 R9 R10)
    for (int pass = 0; pass < 2; pass++) begin
      for (int opi = 0; opi < 16; opi++) begin
        logic [3:0] op;
        bit is_bound;
        op = opi[3:0];
        bist_pass = pass[0];
        for (int i = 0; i < BL; i++) bsr_cap[i] = ((i * 3 + opi + pass) % 7) < 3;
        bist_cnt = 0;
        load_ir(op, capo, oe_ok);
        chk(capo == 4'b0001, "R3 IR capture pattern", {252'd0, capo}, 256'd1);
        chk(oe_ok, "R10 oe during IR scan", {255'd0, oe_ok}, 256'd1);
        chk(clamp_mode == (op == 4'b0100) && highz_mode == (op == 4'b1000) &&
            bsr_drive == (op == 4'b0000 || op == 4'b0100), "R9 mode outputs",
            {253'd0, clamp_mode, highz_mode, bsr_drive},
            {253'd0, op == 4'b0100, op == 4'b1000, op == 4'b0000 || op == 4'b0100});
        is_bound = (op == 4'b0000 || op == 4'b0001);
        exp = '0;
        if (is_bound) begin plen = BL; exp[BL-1:0] = bsr_cap; end
        else if (op == 4'b0010) begin plen = 32; exp[31:0] = IDV; end
        else if (op == 4'b0111) begin plen = 1; exp[0] = pass[0]; end
        else begin plen = 1; exp[0] = 1'b0; end
        for (int i = 0; i < 200; i++) din[i] = ((i * 7 + opi * 3 + pass) % 5) < 2;
        din[255:200] = '0;
        for (int i = plen; i < 200; i++) exp[i] = din[i - plen];
        scan_dr(din, 200, dout, oe_ok);
        step0(0);
        chk(dout[199:0] == exp[199:0], "R4 R5 R6 R7 R8 path length and capture", dout, exp);
        chk(oe_ok, "R10 oe during DR scan", {255'd0, oe_ok}, 256'd1);
        if (is_bound) for (int j = 0; j < BL; j++) upd_model[j] = din[j + 200 - BL];
        chk(bsr_update == upd_model, "R8 update latch", {64'd0, bsr_update}, {64'd0, upd_model});
        chk(bist_cnt == ((op == 4'b0111) ? 2 : 0), "R7 bist_start pulses",
            256'(bist_cnt), 256'((op == 4'b0111) ? 2 : 0));
      end
    end

    // five tms-high cycles from Shift-DR reach reset (R1)
    load_ir(4'b1000, capo, oe_ok);
    step0(1); step0(0); step0(0);
    repeat (5) step0(1);
    step0(1);
    chk(highz_mode == 0, "R1 five tms high resets IR", {255'd0, highz_mode}, 256'd0);
    step0(0);
    read_id("R1 ID after tms reset");

    // asynchronous trst in the middle of a cycle (R2)
    load_ir(4'b0100, capo, oe_ok);
    chk(clamp_mode == 1 && bsr_drive == 1, "R9 clamp loaded", {254'd0, clamp_mode, bsr_drive}, 256'd3);
    @(negedge tck); #1;
    trst_n = 0;
    #1;
    chk(clamp_mode == 0 && bsr_drive == 0 && tdo_oe == 0, "R2 async trst",
        {253'd0, clamp_mode, bsr_drive, tdo_oe}, 256'd0);
    chk(bsr_update == '0, "R2 trst clears update", {64'd0, bsr_update}, 256'd0);
    repeat (3) @(posedge tck);
    @(negedge tck); #1;
    trst_n = 1;
    tms = 1;
    @(posedge tck);
    repeat (4) step0(1);
    step0(0);
    read_id("R2 ID after trst");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge tck);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog R1 got=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule